// File: doc/BRIEF.md
# Serial-Loaded Bank Mapping Controller

This block sits between an 8-bit CPU bus and the memories of a cartridge. It translates CPU accesses into upper address bits for program ROM, pattern memory and work RAM. The CPU cannot write a configuration register in one access. It feeds one data bit per bus write into the upper half of the address space. After five such writes, the collected 5-bit value lands in one of four configuration registers, selected by the address of the last write.

From those registers the block decodes four things: two 16 KB program window bank numbers, two 4 KB pattern window bank numbers, a nametable mirroring code, and the chip select and page for the 8 KB work-RAM window. A write with data bit 7 set aborts any partial load. A second write that arrives one CPU cycle after such an abort is dropped, because a read-modify-write instruction produces two back-to-back writes. A strobe input marks real CPU cycles, so the guard counts bus cycles and not fabric clocks.

Top module: `serial_bank_ctrl`

## Requirements
- R1: After reset the outputs are as follows, with the shift state empty:
  - mirror_sel is 3.
  - Both pattern banks are 0.
  - The low program bank is 0 and the high program bank is 15.
  - The work RAM is enabled.

  The control register holds 0x1F and the other three registers hold 0.
- R2: An accepted write with addr[15]=1 and wdata[7]=1 empties the shift state and forces control bits 3:2 to 1. It leaves control bits 4 and 1:0 unchanged.
- R3: Writes only count when cpu_cycle=1 and wr_en=1. An accepted write with addr[15]=1 and wdata[7]=0 shifts wdata[0] in, least significant bit first. On the fifth such write the value goes to a register picked by addr[14:13]: 0 is control, 1 is pattern-low, 2 is pattern-high and 3 is program. The shift state then empties. Writes with addr[15]=0 do not touch the shift state.
- R4: A register write in the CPU cycle directly after an accepted bit-7 write is ignored. This holds whatever its data and however many clocks separate the two cycles. A write two CPU cycles after it is accepted.
- R5: mirror_sel equals control bits 1:0. The codes are 0 for single-screen A, 1 for single-screen B, 2 for vertical and 3 for horizontal.
- R6: Pattern banks are 4 KB bank numbers.
  - With control bit 4 = 1: chr_bank_lo is pattern-low and chr_bank_hi is pattern-high.
  - With control bit 4 = 0: chr_bank_lo is pattern-low with bit 0 cleared, and chr_bank_hi is pattern-low with bit 0 set.
- R7: The program mode is control bits 3:2.
  - Mode 0 or 1: prg_bank_lo is the program register with bit 0 cleared, and prg_bank_hi is that value plus 1.
  - Mode 2: prg_bank_lo is 0 and prg_bank_hi is the program register.
  - Mode 3: prg_bank_lo is the program register and prg_bank_hi is 15.
- R8: When pattern-low bit 4 is 1, 16 is added to both program bank numbers in every mode, the fixed banks included.
- R9: wram_cs is 1 for addresses 0x6000–0x7FFF when program register bit 4 is 0 or wram_always_on is 1. It is 0 otherwise. wram_we is wram_cs qualified by wr_en and cpu_cycle, so writes to a disabled RAM are dropped.
- R10: When WRAM_PAGES is 2, wram_page is pattern-low bit 4 if control bit 4 is 1, and pattern-low bit 3 otherwise. When WRAM_PAGES is 1, wram_page is 0.
- R11: Bank numbers wrap modulo PRG_BANKS and CHR_BANKS, which are powers of two. With 32 program banks, program register 31 plus the offset of 16 gives 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_cycle | input | 1 | One-clock strobe marking a CPU bus cycle |
| wr_en | input | 1 | CPU write in this cycle |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| wram_always_on | input | 1 | Keeps work RAM enabled regardless of the disable bit |
| mirror_sel | output | 2 | Nametable mirroring code |
| prg_bank_lo | output | PRG_W | 16 KB bank at 0x8000 |
| prg_bank_hi | output | PRG_W | 16 KB bank at 0xC000 |
| chr_bank_lo | output | CHR_W | 4 KB bank at pattern 0x0000 |
| chr_bank_hi | output | CHR_W | 4 KB bank at pattern 0x1000 |
| wram_cs | output | 1 | Work-RAM select for the current address |
| wram_we | output | 1 | Work-RAM write strobe |
| wram_page | output | 1 | 8 KB work-RAM page |

## Verification
The bound checker watches several rules on every clock:
- No register write is accepted in the CPU cycle right after an abort.
- An abort always leaves the fixed-high program mode selected.
- Mirroring changes only on a control-register commit.
- The 8 KB pattern mode always yields an even/odd bank pair.
- The work-RAM write strobe never fires when the RAM is disabled or the address is outside the window.

The bench scenarios cover the rest: the least-significant-bit-first order of the five-write load, the routing by addr[14:13], the four program modes with the outer offset and its wrap, the RAM page choice, and the guard measured in CPU cycles rather than clocks.

// File: rtl/bank_ctrl_pkg.sv
// Package: shared constants and enumerations for the serial bank controller.
// Assumes nothing beyond IEEE 1800-2017.
package bank_ctrl_pkg;

    localparam int CFG_W  = 5;   // width of every configuration register
    localparam int CNT_W  = 3;   // shift bit counter width (0..4)
    localparam int IDX_W  = 2;   // register index width

    // Register index taken from address bits 14:13
    typedef enum logic [IDX_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_PATLO  = 2'd1,
        REG_PATHI  = 2'd2,
        REG_PROG   = 2'd3
    } reg_idx_e;

    // Program window arrangement, control bits 3:2
    typedef enum logic [1:0] {
        PM_PAIR_A  = 2'd0,
        PM_PAIR_B  = 2'd1,
        PM_FIX_LO  = 2'd2,
        PM_FIX_HI  = 2'd3
    } prg_mode_e;

    // Nametable arrangement, control bits 1:0
    typedef enum logic [1:0] {
        MIR_ONE_A  = 2'd0,
        MIR_ONE_B  = 2'd1,
        MIR_VERT   = 2'd2,
        MIR_HORZ   = 2'd3
    } mirror_e;

    localparam logic [CFG_W-1:0] CTRL_RESET = 5'h1F;
    localparam logic [3:0]       LAST_BANK  = 4'hF;

endpackage

// File: rtl/serial_loader.sv
// Module: serial_loader
// Collects one data bit per accepted CPU register write, LSB first, and
// emits a commit pulse with the 5-bit value and the target index after the
// fifth bit. A write with data bit 7 set aborts the load. A register write
// in the CPU cycle right after an abort is rejected; the age counter
// advances only on cpu_cycle strobes. Assumes GUARD_CYCLES >= 2.
module serial_loader
    import bank_ctrl_pkg::*;
#(
    parameter int GUARD_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_cycle,
    input  logic             wr_en,
    input  logic [15:0]      addr,
    input  logic [7:0]       wdata,
    output logic             accept,
    output logic             abort_pulse,
    output logic             commit,
    output logic [IDX_W-1:0] commit_idx,
    output logic [CFG_W-1:0] commit_val
);

    localparam int AGE_W = (GUARD_CYCLES > 2) ? $clog2(GUARD_CYCLES) : 1;
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(GUARD_CYCLES - 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CFG_W - 1);

    logic [CFG_W-1:0] shift_q;
    logic [CNT_W-1:0] count_q;
    logic [AGE_W-1:0] age_q;
    logic             bit_write;

    // Decode which bus writes reach the register port and what they do
    always_comb begin
        accept      = cpu_cycle && wr_en && addr[15] && (age_q == AGE_MAX);
        abort_pulse = accept && wdata[7];
        bit_write   = accept && !wdata[7];
        commit      = bit_write && (count_q == LAST_BIT);
        commit_idx  = addr[14:13];
        commit_val  = {wdata[0], shift_q[CFG_W-1:1]};
    end

    // Shift register, bit counter and abort age state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            count_q <= '0;
            age_q   <= AGE_MAX;
        end else if (abort_pulse) begin
            shift_q <= '0;
            count_q <= '0;
            age_q   <= '0;
        end else begin
            if (cpu_cycle && (age_q != AGE_MAX)) begin
                age_q <= age_q + 1'b1;
            end
            if (bit_write) begin
                if (commit) begin
                    shift_q <= '0;
                    count_q <= '0;
                end else begin
                    shift_q <= {wdata[0], shift_q[CFG_W-1:1]};
                    count_q <= count_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cfg_regs.sv
// Module: cfg_regs
// Holds the four 5-bit configuration registers. A commit writes the
// indexed register; an abort forces control bits 3:2 high.
// Assumes commit and abort never coincide (guaranteed by the loader).
module cfg_regs
    import bank_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort_pulse,
    input  logic             commit,
    input  logic [IDX_W-1:0] commit_idx,
    input  logic [CFG_W-1:0] commit_val,
    output logic [CFG_W-1:0] ctrl,
    output logic [CFG_W-1:0] pat_lo,
    output logic [CFG_W-1:0] pat_hi,
    output logic [CFG_W-1:0] prog
);

    localparam int NREGS = 1 << IDX_W;

    logic [CFG_W-1:0] regs_q [NREGS];

    // One storage element per register index
    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam logic [CFG_W-1:0] RST_VAL = (g == int'(REG_CTRL)) ? CTRL_RESET : '0;
        // Reset value, commit load and, for control only, the abort force
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[g] <= RST_VAL;
            end else if (commit && (commit_idx == IDX_W'(g))) begin
                regs_q[g] <= commit_val;
            end else if (abort_pulse && (g == int'(REG_CTRL))) begin
                regs_q[g][3:2] <= 2'b11;
            end
        end
    end

    // Name the register outputs
    always_comb begin
        ctrl   = regs_q[REG_CTRL];
        pat_lo = regs_q[REG_PATLO];
        pat_hi = regs_q[REG_PATHI];
        prog   = regs_q[REG_PROG];
    end

endmodule

// File: rtl/bank_decode.sv
// Module: bank_decode
// Turns the configuration registers into program and pattern bank numbers
// and the mirroring code. Purely combinational. Assumes PRG_BANKS and
// CHR_BANKS are powers of two no larger than 256, so truncation wraps.
module bank_decode
    import bank_ctrl_pkg::*;
#(
    parameter int PRG_W = 5,
    parameter int CHR_W = 5
) (
    input  logic [CFG_W-1:0] ctrl,
    input  logic [CFG_W-1:0] pat_lo,
    input  logic [CFG_W-1:0] pat_hi,
    input  logic [CFG_W-1:0] prog,
    output logic [1:0]       mirror_sel,
    output logic [PRG_W-1:0] prg_bank_lo,
    output logic [PRG_W-1:0] prg_bank_hi,
    output logic [CHR_W-1:0] chr_bank_lo,
    output logic [CHR_W-1:0] chr_bank_hi
);

    localparam int WIDE = 8;

    prg_mode_e       mode;
    logic [WIDE-1:0] outer;
    logic [WIDE-1:0] prog_w;
    logic [WIDE-1:0] pair_base;
    logic [WIDE-1:0] lo_full;
    logic [WIDE-1:0] hi_full;
    logic [WIDE-1:0] clo_full;
    logic [WIDE-1:0] chi_full;

    // Program window bank selection including the outer offset
    always_comb begin
        mode      = prg_mode_e'(ctrl[3:2]);
        outer     = {3'b000, pat_lo[4], 4'b0000};
        prog_w    = {3'b000, prog};
        pair_base = {prog_w[WIDE-1:1], 1'b0};
        case (mode)
            PM_FIX_HI: begin
                lo_full = prog_w + outer;
                hi_full = {4'b0000, LAST_BANK} + outer;
            end
            PM_FIX_LO: begin
                lo_full = outer;
                hi_full = prog_w + outer;
            end
            default: begin
                lo_full = pair_base + outer;
                hi_full = pair_base + outer + 1'b1;
            end
        endcase
        prg_bank_lo = lo_full[PRG_W-1:0];
        prg_bank_hi = hi_full[PRG_W-1:0];
    end

    // Pattern window bank selection, split or paired 4 KB halves
    always_comb begin
        if (ctrl[4]) begin
            clo_full = {3'b000, pat_lo};
            chi_full = {3'b000, pat_hi};
        end else begin
            clo_full = {3'b000, pat_lo[4:1], 1'b0};
            chi_full = {3'b000, pat_lo[4:1], 1'b1};
        end
        chr_bank_lo = clo_full[CHR_W-1:0];
        chr_bank_hi = chi_full[CHR_W-1:0];
    end

    // Mirroring code passes straight from control bits 1:0
    always_comb begin
        mirror_sel = ctrl[1:0];
    end

endmodule

// File: rtl/wram_gate.sv
// Module: wram_gate
// Decodes the 0x6000-0x7FFF work-RAM window, applies the disable bit unless
// the override input holds it on, and picks the 8 KB page when two are
// fitted. Combinational. Assumes WRAM_PAGES is 1 or 2.
module wram_gate
    import bank_ctrl_pkg::*;
#(
    parameter int WRAM_PAGES = 2
) (
    input  logic             cpu_cycle,
    input  logic             wr_en,
    input  logic [15:0]      addr,
    input  logic             always_on,
    input  logic [CFG_W-1:0] ctrl,
    input  logic [CFG_W-1:0] pat_lo,
    input  logic [CFG_W-1:0] prog,
    output logic             wram_cs,
    output logic             wram_we,
    output logic             wram_page
);

    logic in_window;
    logic enabled;

    // Window hit, enable and write strobe
    always_comb begin
        in_window = (addr[15:13] == 3'b011);
        enabled   = always_on || !prog[4];
        wram_cs   = in_window && enabled;
        wram_we   = wram_cs && wr_en && cpu_cycle;
    end

    if (WRAM_PAGES > 1) begin : g_two_pages
        // Page bit follows the pattern mode
        always_comb begin
            wram_page = ctrl[4] ? pat_lo[4] : pat_lo[3];
        end
    end else begin : g_one_page
        // Single page fitted
        always_comb begin
            wram_page = 1'b0;
        end
    end

endmodule

// File: rtl/serial_bank_ctrl.sv
// Module: serial_bank_ctrl (top)
// Serial-loaded bank mapping controller: loader, register file, bank
// decoder and work-RAM gate. Assumes cpu_cycle is high for exactly one
// clock per CPU bus cycle and that wr_en/addr/wdata are valid with it.
module serial_bank_ctrl
    import bank_ctrl_pkg::*;
#(
    parameter int PRG_BANKS    = 32,
    parameter int CHR_BANKS    = 32,
    parameter int WRAM_PAGES   = 2,
    parameter int GUARD_CYCLES = 2,
    localparam int PRG_W       = $clog2(PRG_BANKS),
    localparam int CHR_W       = $clog2(CHR_BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_cycle,
    input  logic             wr_en,
    input  logic [15:0]      addr,
    input  logic [7:0]       wdata,
    input  logic             wram_always_on,
    output logic [1:0]       mirror_sel,
    output logic [PRG_W-1:0] prg_bank_lo,
    output logic [PRG_W-1:0] prg_bank_hi,
    output logic [CHR_W-1:0] chr_bank_lo,
    output logic [CHR_W-1:0] chr_bank_hi,
    output logic             wram_cs,
    output logic             wram_we,
    output logic             wram_page
);

    logic             accept;
    logic             abort_pulse;
    logic             commit;
    logic [IDX_W-1:0] commit_idx;
    logic [CFG_W-1:0] commit_val;
    logic [CFG_W-1:0] ctrl_r;
    logic [CFG_W-1:0] patlo_r;
    logic [CFG_W-1:0] pathi_r;
    logic [CFG_W-1:0] prog_r;

    serial_loader #(.GUARD_CYCLES(GUARD_CYCLES)) u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_cycle  (cpu_cycle),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .accept     (accept),
        .abort_pulse(abort_pulse),
        .commit     (commit),
        .commit_idx (commit_idx),
        .commit_val (commit_val)
    );

    cfg_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort_pulse(abort_pulse),
        .commit     (commit),
        .commit_idx (commit_idx),
        .commit_val (commit_val),
        .ctrl       (ctrl_r),
        .pat_lo     (patlo_r),
        .pat_hi     (pathi_r),
        .prog       (prog_r)
    );

    bank_decode #(.PRG_W(PRG_W), .CHR_W(CHR_W)) u_decode (
        .ctrl       (ctrl_r),
        .pat_lo     (patlo_r),
        .pat_hi     (pathi_r),
        .prog       (prog_r),
        .mirror_sel (mirror_sel),
        .prg_bank_lo(prg_bank_lo),
        .prg_bank_hi(prg_bank_hi),
        .chr_bank_lo(chr_bank_lo),
        .chr_bank_hi(chr_bank_hi)
    );

    wram_gate #(.WRAM_PAGES(WRAM_PAGES)) u_wram (
        .cpu_cycle (cpu_cycle),
        .wr_en     (wr_en),
        .addr      (addr),
        .always_on (wram_always_on),
        .ctrl      (ctrl_r),
        .pat_lo    (patlo_r),
        .prog      (prog_r),
        .wram_cs   (wram_cs),
        .wram_we   (wram_we),
        .wram_page (wram_page)
    );

endmodule

// File: rtl/serial_bank_ctrl_chk.sv
// Module: serial_bank_ctrl_chk
// Checker bound into serial_bank_ctrl. It keeps its own count of CPU cycles
// since the last accepted abort and checks per-cycle rules on ports and
// on signals that separate submodules drive.
module serial_bank_ctrl_chk #(
    parameter int PRG_W = 5,
    parameter int CHR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_cycle,
    input logic             wr_en,
    input logic [15:0]      addr,
    input logic [7:0]       wdata,
    input logic             wram_always_on,
    input logic             accept,
    input logic             commit,
    input logic [1:0]       commit_idx,
    input logic [4:0]       ctrl_r,
    input logic [4:0]       prog_r,
    input logic [1:0]       mirror_sel,
    input logic [CHR_W-1:0] chr_bank_lo,
    input logic [CHR_W-1:0] chr_bank_hi,
    input logic             wram_we
);

    logic [1:0] since_abort;

    // Count CPU cycles after the last accepted abort, saturating at 2
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_abort <= 2'd2;
        end else if (accept && wdata[7]) begin
            since_abort <= 2'd0;
        end else if (cpu_cycle && since_abort != 2'd2) begin
            since_abort <= since_abort + 2'd1;
        end
    end

    // R4: nothing accepted in the CPU cycle right after an abort
    p_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_cycle && since_abort == 2'd0) |-> !accept);

    // R2: an accepted abort leaves the fixed-high program mode
    p_abort_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wdata[7]) |=> (ctrl_r[3:2] == 2'b11));

    // R5: mirroring only moves on a commit to the control register
    p_mirror_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && commit_idx == 2'd0) |=> $stable(mirror_sel));

    // R6: paired 8 KB mode always yields an even/odd pair
    p_chr_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_r[4] |-> (chr_bank_lo[0] == 1'b0 && chr_bank_hi == (chr_bank_lo | CHR_W'(1))));

    // R9: RAM writes only in the window and only while enabled
    p_wram_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wram_we |-> (addr[15:13] == 3'b011 && wr_en && (wram_always_on || !prog_r[4])));

    // R3: commits only come from accepted writes with bit 7 clear
    p_commit_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (accept && !wdata[7] && addr[15]));

endmodule

bind serial_bank_ctrl serial_bank_ctrl_chk #(.PRG_W(PRG_W), .CHR_W(CHR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_cycle     (cpu_cycle),
    .wr_en         (wr_en),
    .addr          (addr),
    .wdata         (wdata),
    .wram_always_on(wram_always_on),
    .accept        (accept),
    .commit        (commit),
    .commit_idx    (commit_idx),
    .ctrl_r        (ctrl_r),
    .prog_r        (prog_r),
    .mirror_sel    (mirror_sel),
    .chr_bank_lo   (chr_bank_lo),
    .chr_bank_hi   (chr_bank_hi),
    .wram_we       (wram_we)
);

// File: tb/sim_serial_bank_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated on each rising edge and
// compared with every output on each falling edge, plus directed checks.
module sim_serial_bank_ctrl;

    localparam int PRG_BANKS = 32;
    localparam int CHR_BANKS = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_cycle = 1'b0;
    logic       wr_en = 1'b0;
    logic [15:0] addr = 16'h6000;
    logic [7:0] wdata = 8'h00;
    logic       wram_always_on = 1'b0;
    logic [1:0] mirror_sel;
    logic [4:0] prg_bank_lo, prg_bank_hi, chr_bank_lo, chr_bank_hi;
    logic       wram_cs, wram_we, wram_page;

    int checks = 0;
    int fails  = 0;
    bit running = 0;

    // Reference model state
    int m_regs [4];
    int m_shift, m_nbits, m_cpu, m_last_abort;

    always #2 clk = ~clk;

    serial_bank_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cpu_cycle(cpu_cycle), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .wram_always_on(wram_always_on),
        .mirror_sel(mirror_sel), .prg_bank_lo(prg_bank_lo),
        .prg_bank_hi(prg_bank_hi), .chr_bank_lo(chr_bank_lo),
        .chr_bank_hi(chr_bank_hi), .wram_cs(wram_cs), .wram_we(wram_we),
        .wram_page(wram_page)
    );

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Model update on the rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_regs[0] = 31; m_regs[1] = 0; m_regs[2] = 0; m_regs[3] = 0;
            m_shift = 0; m_nbits = 0; m_cpu = 0; m_last_abort = -1000;
        end else if (cpu_cycle) begin
            if (wr_en && addr[15] && (m_cpu - m_last_abort >= 2)) begin
                if (wdata[7]) begin
                    m_shift = 0; m_nbits = 0;
                    m_regs[0] = m_regs[0] | 12;
                    m_last_abort = m_cpu;
                end else begin
                    m_shift = m_shift | (int'(wdata[0]) << m_nbits);
                    m_nbits++;
                    if (m_nbits == 5) begin
                        m_regs[int'(addr[14:13])] = m_shift;
                        m_shift = 0; m_nbits = 0;
                    end
                end
            end
            m_cpu++;
        end
    end

    // Compare every output with the model on the falling edge
    always @(negedge clk) begin
        if (running && rst_n) begin
            int off, lo, hi, cl, ch, en, pg;
            off = ((m_regs[1] >> 4) & 1) * 16;
            case ((m_regs[0] >> 2) & 3)
                3: begin lo = m_regs[3] + off; hi = 15 + off; end
                2: begin lo = off; hi = m_regs[3] + off; end
                default: begin lo = (m_regs[3] & 30) + off; hi = lo + 1; end
            endcase
            if (m_regs[0] & 16) begin cl = m_regs[1]; ch = m_regs[2]; end
            else begin cl = m_regs[1] & 30; ch = (m_regs[1] & 30) + 1; end
            en = ((addr >= 16'h6000) && (addr <= 16'h7FFF) &&
                  (wram_always_on || !((m_regs[3] >> 4) & 1))) ? 1 : 0;
            pg = (m_regs[0] & 16) ? ((m_regs[1] >> 4) & 1) : ((m_regs[1] >> 3) & 1);
            chk(int'(mirror_sel), m_regs[0] & 3, "R5 mirror");
            chk(int'(prg_bank_lo), lo % PRG_BANKS, "R7/R8/R11 prg_lo");
            chk(int'(prg_bank_hi), hi % PRG_BANKS, "R7/R8/R11 prg_hi");
            chk(int'(chr_bank_lo), cl % CHR_BANKS, "R6 chr_lo");
            chk(int'(chr_bank_hi), ch % CHR_BANKS, "R6 chr_hi");
            chk(int'(wram_cs), en, "R9 wram_cs");
            chk(int'(wram_we), en & int'(wr_en) & int'(cpu_cycle), "R9 wram_we");
            chk(int'(wram_page), pg, "R10 wram_page");
        end
    end

    // One CPU cycle, then gap clocks with the strobe low
    task automatic tick(input bit w, input logic [15:0] a, input logic [7:0] d, input int gap);
        cpu_cycle = 1'b1; wr_en = w; addr = a; wdata = d;
        @(posedge clk); #1;
        cpu_cycle = 1'b0; wr_en = 1'b0;
        for (int i = 0; i < gap; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic load(input int idx, input int val, input int gap);
        for (int i = 0; i < 5; i++)
            tick(1'b1, 16'h8000 | 16'(idx << 13), 8'((val >> i) & 1), gap);
    endtask

    task automatic abort_wr(input int gap);
        tick(1'b1, 16'hFFFF, 8'h80, gap);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        running = 1;
        @(negedge clk);
        // R1 reset state
        chk(int'(mirror_sel), 3, "R1 mirror");
        chk(int'(prg_bank_lo), 0, "R1 prg_lo");
        chk(int'(prg_bank_hi), 15, "R1 prg_hi");
        chk(int'(chr_bank_lo), 0, "R1 chr_lo");
        chk(int'(chr_bank_hi), 0, "R1 chr_hi");
        chk(int'(wram_cs), 1, "R1 wram enabled");
        @(posedge clk); #1;

        // R5 each mirroring code, R3 control loads via 0x8000
        for (int m = 0; m < 4; m++) begin
            load(0, 16 | 12 | m, m);
            @(negedge clk); chk(int'(mirror_sel), m, "R5 code"); @(posedge clk); #1;
        end
        // R6 split pattern banks, R3 routing by addr[14:13]
        load(1, 5'h0B, 0); load(2, 5'h15, 1);
        @(negedge clk);
        chk(int'(chr_bank_lo), 11, "R6 split lo"); chk(int'(chr_bank_hi), 21, "R6 split hi");
        @(posedge clk); #1;
        // R3 writes outside 0x8000-0xFFFF do not advance the shifter
        tick(1'b1, 16'h8000, 8'h01, 0); tick(1'b1, 16'h6000, 8'h00, 0);
        tick(1'b1, 16'h4020, 8'h00, 0);
        for (int i = 0; i < 4; i++) tick(1'b1, 16'hC000, 8'h00, 0);
        @(negedge clk); chk(int'(chr_bank_hi), 1, "R3 lsb first, foreign writes ignored");
        @(posedge clk); #1;
        // R6 paired mode
        load(0, 5'h0E, 0);
        @(negedge clk);
        chk(int'(chr_bank_lo), 10, "R6 pair lo"); chk(int'(chr_bank_hi), 11, "R6 pair hi");
        @(posedge clk); #1;
        // R7/R8/R11 program modes with and without outer offset
        for (int md = 0; md < 4; md++) begin
            load(0, 16 | (md << 2), 0);
            for (int r = 0; r < 32; r += 7) begin
                load(3, r, 0);
                load(1, 0, 0);
                load(1, 16, 0);
            end
            load(3, 31, 0);
        end
        load(0, 5'h1C, 0); load(1, 16, 0); load(3, 31, 0);
        @(negedge clk); chk(int'(prg_bank_lo), 15, "R11 wrap 31+16"); @(posedge clk); #1;
        // R10 RAM page in both pattern modes
        load(1, 5'h08, 0); load(0, 5'h00, 0);
        @(negedge clk); chk(int'(wram_page), 1, "R10 page bit3"); @(posedge clk); #1;
        load(0, 5'h10, 0);
        @(negedge clk); chk(int'(wram_page), 0, "R10 page bit4"); @(posedge clk); #1;
        // R9 disable bit and override
        load(3, 5'h10, 0);
        tick(1'b1, 16'h6123, 8'h55, 0);
        @(negedge clk); chk(int'(wram_cs), 0, "R9 disabled"); @(posedge clk); #1;
        wram_always_on = 1'b1;
        tick(1'b1, 16'h7FFF, 8'h55, 1);
        wram_always_on = 1'b0;
        load(3, 5'h00, 0);
        // R2 abort mid-load keeps ctrl bits 4 and 1:0
        load(0, 5'h12, 0);
        tick(1'b1, 16'hA000, 8'h01, 0); tick(1'b1, 16'hA000, 8'h01, 0);
        abort_wr(0); tick(1'b0, 16'h0000, 8'h00, 0);
        load(1, 5'h04, 0);
        @(negedge clk);
        chk(int'(chr_bank_lo), 4, "R2 shift emptied");
        chk(int'(mirror_sel), 2, "R2 mirror kept");
        chk(int'(prg_bank_hi), 15, "R2 mode forced fixed-high");
        @(posedge clk); #1;
        // R4 write one CPU cycle after abort is ignored, clocks apart
        abort_wr(5);
        tick(1'b1, 16'hA000, 8'h01, 3);
        load(1, 5'h03, 0);
        @(negedge clk); chk(int'(chr_bank_lo), 3, "R4 early write ignored"); @(posedge clk); #1;
        // R4 second abort in the guard cycle is ignored too
        load(0, 5'h10, 0);
        abort_wr(0); tick(1'b1, 16'h8000, 8'h80, 0);
        // R4 write exactly two CPU cycles after abort is accepted
        abort_wr(0); tick(1'b0, 16'h0000, 8'h00, 0);
        load(1, 5'h06, 2);
        @(negedge clk); chk(int'(chr_bank_lo), 6, "R4 write at two cycles accepted"); @(posedge clk); #1;

        repeat (4) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule